// File: doc/BRIEF.md
# Single-Entry ARP Resolver

This block answers the address-resolution needs of one local station, identified by its 32-bit IP address and 48-bit MAC address. It listens to the byte-wide MAC receive stream alongside the IPv4 receive path and parses ARP packets. It also counts every well-formed ARP packet in an 8-bit wrapping counter.

When it receives an ARP request for the local IP, it queues a reply frame. The IPv4 transmit path asks it for the MAC of a destination IP before it sends. If the one-entry cache holds that IP, the answer comes back on the next cycle. Otherwise the block broadcasts an ARP request and waits for a matching reply. If no reply arrives within a timeout, it reports failure.

The block has three cooperating state machines:
- The receive parser (byte index counter, no named states).
- The frame sender, with states `TX_IDLE` and `TX_SEND`. `TX_IDLE` goes to `TX_SEND` when a frame is started. `TX_SEND` goes back to `TX_IDLE` after the 42nd byte is accepted.
- The resolver, with states `RS_IDLE`, `RS_SEND` and `RS_WAIT`.
  - `RS_IDLE` goes to `RS_SEND` on a request that misses the cache.
  - `RS_SEND` goes to `RS_WAIT` once the sender takes the request frame.
  - `RS_WAIT` goes back to `RS_IDLE` on a matching reply or on timer expiry.

Top module: `arp_resolver_top`

## Requirements
- R1: After reset the design is quiet: `tx_tvalid` and `rsv_done` are 0, and `rx_arp_count` is 0.
- R2: A resolution request that misses the cache makes the block emit one 42-byte broadcast request frame. Its bytes are, in order:
  - bytes 0-5: FF (broadcast destination);
  - bytes 6-11: local MAC (source);
  - bytes 12-13: type 08 06;
  - bytes 14-15: hardware type 00 01;
  - bytes 16-17: protocol type 08 00;
  - byte 18: 06; byte 19: 04;
  - bytes 20-21: opcode 00 01;
  - bytes 22-27: local MAC (sender MAC);
  - bytes 28-31: local IP (sender IP);
  - bytes 32-37: zeros (target MAC);
  - bytes 38-41: requested IP (target IP).

  All multi-byte fields are sent most significant byte first. `tx_tlast` is high on byte 41 only.
- R3: While `tx_tvalid` is high and `tx_tready` is low, `tx_tdata` and `tx_tlast` hold their values.
- R4: While a resolution waits, a received reply (opcode 2) whose sender IP equals the requested IP does three things:
  - it ends the wait with a single-cycle `rsv_done`;
  - it sets `rsv_ok`=1 and `rsv_mac` = the sender MAC (bytes 22-27);
  - it stores that mapping in the cache.
- R5: A request whose IP equals the cached IP completes with `rsv_done`, `rsv_ok`=1 and the cached MAC one cycle after the request is sampled. No frame is sent.
- R6: If no matching reply arrives within `TIMEOUT_CYCLES` cycles after the request frame is started, the block raises `rsv_done` with `rsv_ok`=0 and `rsv_mac`=0.
- R7: A received request (opcode 1) whose target IP (bytes 38-41) equals the local IP causes a 42-byte reply frame. It has the R2 layout with these differences:
  - opcode is 2;
  - the destination MAC and the target MAC are the requester's sender MAC;
  - the target IP is the requester's sender IP.
- R8: A received request whose target IP is not the local IP causes no frame.
- R9: `rx_arp_count` increments by one, modulo 256, for each received frame that meets all of these conditions:
  - it is at least 42 bytes long;
  - bytes 12-20 match the R2 header constants;
  - its opcode is 1 or 2.

  Other frames, such as a different type field or a frame ending before byte 41, do not change it.
- R10: A reply whose sender IP differs from the pending IP neither completes the resolution nor changes the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| our_mac | input | 48 | Local MAC address |
| our_ip | input | 32 | Local IP address |
| rx_tdata | input | 8 | Receive byte |
| rx_tvalid | input | 1 | Receive byte valid |
| rx_tlast | input | 1 | Last byte of received frame |
| tx_tdata | output | 8 | Transmit byte |
| tx_tvalid | output | 1 | Transmit byte valid |
| tx_tready | input | 1 | MAC accepts transmit byte |
| tx_tlast | output | 1 | Last byte of transmitted frame |
| rsv_req | input | 1 | Resolution request pulse |
| rsv_ip | input | 32 | IP address to resolve |
| rsv_done | output | 1 | Resolution finished (one cycle) |
| rsv_ok | output | 1 | Resolution succeeded |
| rsv_mac | output | 48 | Resolved MAC address |
| rx_arp_count | output | 8 | Count of received ARP packets |

## Verification
The hardest situation to reach is a resolution that is still waiting when an unrelated reply arrives. That reply must be counted but must not complete the wait. To get there, the stimulus first lets the whole broadcast request frame drain through a stuttering `tx_tready`. It then injects a reply from a different sender IP, and only after that sends the matching one. Any early `rsv_done` therefore pops the scoreboard with the wrong MAC. The timeout path is reached by leaving a second miss unanswered for the full window.

// File: rtl/arp_pkg.sv
package arp_pkg;
    localparam int FRAME_BYTES = 42;
    localparam int IDX_W       = 6;

    typedef enum logic [1:0] {RS_IDLE, RS_SEND, RS_WAIT} rs_state_t;
    typedef enum logic       {TX_IDLE, TX_SEND} tx_state_t;

    // Byte at position idx of an outgoing ARP frame (MSB first fields).
    function automatic logic [7:0] arp_frame_byte(
        input logic [IDX_W-1:0] idx,
        input logic             is_reply,
        input logic [47:0]      dst_mac,
        input logic [47:0]      src_mac,
        input logic [31:0]      src_ip,
        input logic [31:0]      tgt_ip
    );
        int          i;
        logic [47:0] tha;
        logic [7:0]  b;
        i   = int'(idx);
        tha = is_reply ? dst_mac : 48'h0;
        b   = 8'h00;
        if (i < 6)       b = dst_mac[8*(5-i) +: 8];
        else if (i < 12) b = src_mac[8*(11-i) +: 8];
        else if (i < 22) begin
            unique case (i)
                12: b = 8'h08;  13: b = 8'h06;
                14: b = 8'h00;  15: b = 8'h01;
                16: b = 8'h08;  17: b = 8'h00;
                18: b = 8'h06;  19: b = 8'h04;
                20: b = 8'h00;
                default: b = is_reply ? 8'h02 : 8'h01;
            endcase
        end
        else if (i < 28) b = src_mac[8*(27-i) +: 8];
        else if (i < 32) b = src_ip[8*(31-i) +: 8];
        else if (i < 38) b = tha[8*(37-i) +: 8];
        else if (i < 42) b = tgt_ip[8*(41-i) +: 8];
        return b;
    endfunction
endpackage

// File: rtl/arp_rx_parser.sv
module arp_rx_parser
    import arp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_tdata,
    input  logic        rx_tvalid,
    input  logic        rx_tlast,
    output logic        pkt_stb,
    output logic        pkt_is_reply,
    output logic [47:0] pkt_sha,
    output logic [31:0] pkt_spa,
    output logic [31:0] pkt_tpa
);
    localparam logic [IDX_W-1:0] IDX_MAX  = '1;
    localparam logic [IDX_W-1:0] IDX_DONE = IDX_W'(FRAME_BYTES-1);

    logic [IDX_W-1:0] idx;
    logic             bad;
    logic [7:0]       op_q;

    assign pkt_is_reply = (op_q == 8'h02);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0; bad <= 1'b0; op_q <= '0; pkt_stb <= 1'b0;
            pkt_sha <= '0; pkt_spa <= '0; pkt_tpa <= '0;
        end else begin
            pkt_stb <= 1'b0;
            if (rx_tvalid) begin
                if (idx >= 6'd12 && idx <= 6'd20 &&
                    rx_tdata != arp_frame_byte(idx, 1'b0, '0, '0, '0, '0))
                    bad <= 1'b1;
                if (idx == 6'd21) begin
                    op_q <= rx_tdata;
                    if (rx_tdata != 8'h01 && rx_tdata != 8'h02) bad <= 1'b1;
                end
                if (idx >= 6'd22 && idx <= 6'd27) pkt_sha <= {pkt_sha[39:0], rx_tdata};
                if (idx >= 6'd28 && idx <= 6'd31) pkt_spa <= {pkt_spa[23:0], rx_tdata};
                if (idx >= 6'd38 && idx <= 6'd41) pkt_tpa <= {pkt_tpa[23:0], rx_tdata};
                if (idx == IDX_DONE && !bad) pkt_stb <= 1'b1;
                if (rx_tlast) begin
                    idx <= '0;
                    bad <= 1'b0;
                end else if (idx != IDX_MAX) begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/arp_tx_framer.sv
module arp_tx_framer
    import arp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        start_reply,
    input  logic [47:0] start_mac,
    input  logic [31:0] start_ip,
    input  logic [47:0] our_mac,
    input  logic [31:0] our_ip,
    output logic        busy,
    output logic [7:0]  tx_tdata,
    output logic        tx_tvalid,
    input  logic        tx_tready,
    output logic        tx_tlast
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES-1);

    tx_state_t        state, nxt;
    logic [IDX_W-1:0] idx;
    logic             f_reply;
    logic [47:0]      f_mac;
    logic [31:0]      f_ip;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE; idx <= '0; f_reply <= 1'b0; f_mac <= '0; f_ip <= '0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE && start) begin
                idx     <= '0;
                f_reply <= start_reply;
                f_mac   <= start_reply ? start_mac : 48'hFFFF_FFFF_FFFF;
                f_ip    <= start_ip;
            end else if (state == TX_SEND && tx_tready) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        nxt       = state;
        tx_tvalid = 1'b0;
        tx_tlast  = 1'b0;
        tx_tdata  = arp_frame_byte(idx, f_reply, f_mac, our_mac, our_ip, f_ip);
        unique case (state)
            TX_IDLE: if (start) nxt = TX_SEND;
            TX_SEND: begin
                tx_tvalid = 1'b1;
                tx_tlast  = (idx == LAST_IDX);
                if (tx_tlast && tx_tready) nxt = TX_IDLE;
            end
            default: nxt = TX_IDLE;
        endcase
    end

    assign busy = (state != TX_IDLE);
endmodule

// File: rtl/arp_resolve_fsm.sv
module arp_resolve_fsm
    import arp_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [31:0] req_ip,
    input  logic        rx_stb,
    input  logic        rx_is_reply,
    input  logic [47:0] rx_sha,
    input  logic [31:0] rx_spa,
    input  logic        tx_grant,
    output logic        tx_want,
    output logic [31:0] want_ip,
    output logic        done,
    output logic        ok,
    output logic [47:0] mac
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

    rs_state_t   state, nxt;
    logic        cache_vld;
    logic [31:0] cache_ip;
    logic [47:0] cache_mac;
    logic [TW-1:0] timer;
    logic        hit, match, expire;

    assign hit     = cache_vld && (cache_ip == req_ip);
    assign match   = rx_stb && rx_is_reply && (rx_spa == want_ip);
    assign expire  = (timer == TW'(TIMEOUT_CYCLES - 1));

    always_comb begin
        nxt     = state;
        tx_want = 1'b0;
        unique case (state)
            RS_IDLE: if (req && !hit) nxt = RS_SEND;
            RS_SEND: begin
                tx_want = 1'b1;
                if (tx_grant) nxt = RS_WAIT;
            end
            RS_WAIT: if (match || expire) nxt = RS_IDLE;
            default: nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE; cache_vld <= 1'b0; cache_ip <= '0; cache_mac <= '0;
            want_ip <= '0; timer <= '0; done <= 1'b0; ok <= 1'b0; mac <= '0;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            if (state == RS_IDLE && req) begin
                if (hit) begin
                    done <= 1'b1; ok <= 1'b1; mac <= cache_mac;
                end else begin
                    want_ip <= req_ip;
                end
            end
            if (state == RS_SEND) timer <= '0;
            if (state == RS_WAIT) begin
                timer <= timer + 1'b1;
                if (match) begin
                    cache_vld <= 1'b1; cache_ip <= want_ip; cache_mac <= rx_sha;
                    done <= 1'b1; ok <= 1'b1; mac <= rx_sha;
                end else if (expire) begin
                    done <= 1'b1; ok <= 1'b0; mac <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/arp_resolver_top.sv
module arp_resolver_top
    import arp_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] our_mac,
    input  logic [31:0] our_ip,
    input  logic [7:0]  rx_tdata,
    input  logic        rx_tvalid,
    input  logic        rx_tlast,
    output logic [7:0]  tx_tdata,
    output logic        tx_tvalid,
    input  logic        tx_tready,
    output logic        tx_tlast,
    input  logic        rsv_req,
    input  logic [31:0] rsv_ip,
    output logic        rsv_done,
    output logic        rsv_ok,
    output logic [47:0] rsv_mac,
    output logic [7:0]  rx_arp_count
);
    logic        pkt_stb, pkt_is_reply;
    logic [47:0] pkt_sha;
    logic [31:0] pkt_spa, pkt_tpa;
    logic        tx_busy, tx_start, tx_grant, res_want;
    logic [31:0] res_ip;
    logic        rp_pend;
    logic [47:0] rp_mac;
    logic [31:0] rp_ip;

    arp_rx_parser u_rx (
        .clk, .rst, .rx_tdata, .rx_tvalid, .rx_tlast,
        .pkt_stb, .pkt_is_reply, .pkt_sha, .pkt_spa, .pkt_tpa
    );

    arp_resolve_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_res (
        .clk, .rst, .req(rsv_req), .req_ip(rsv_ip),
        .rx_stb(pkt_stb), .rx_is_reply(pkt_is_reply), .rx_sha(pkt_sha), .rx_spa(pkt_spa),
        .tx_grant, .tx_want(res_want), .want_ip(res_ip),
        .done(rsv_done), .ok(rsv_ok), .mac(rsv_mac)
    );

    // Replies to incoming requests win the sender over our own requests.
    assign tx_start = !tx_busy && (rp_pend || res_want);
    assign tx_grant = tx_start && !rp_pend;

    arp_tx_framer u_tx (
        .clk, .rst, .start(tx_start), .start_reply(rp_pend),
        .start_mac(rp_mac), .start_ip(rp_pend ? rp_ip : res_ip),
        .our_mac, .our_ip, .busy(tx_busy),
        .tx_tdata, .tx_tvalid, .tx_tready, .tx_tlast
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_pend <= 1'b0; rp_mac <= '0; rp_ip <= '0; rx_arp_count <= '0;
        end else begin
            if (tx_start && rp_pend) rp_pend <= 1'b0;
            if (pkt_stb) begin
                rx_arp_count <= rx_arp_count + 8'd1;
                if (!pkt_is_reply && pkt_tpa == our_ip) begin
                    rp_pend <= 1'b1; rp_mac <= pkt_sha; rp_ip <= pkt_spa;
                end
            end
        end
    end
endmodule

// File: rtl/arp_resolver_chk.sv
module arp_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  tx_tdata,
    input logic        tx_tvalid,
    input logic        tx_tready,
    input logic        tx_tlast,
    input logic        rsv_done,
    input logic        rsv_ok,
    input logic [47:0] rsv_mac,
    input logic [7:0]  rx_arp_count
);
    assert_last_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        tx_tlast |-> tx_tvalid);

    assert_hold_when_stalled_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        rsv_done |=> !rsv_done);

    assert_fail_clears_mac_R6: assert property (@(posedge clk) disable iff (rst)
        (rsv_done && !rsv_ok) |-> (rsv_mac == 48'h0));

    assert_count_steps_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rx_arp_count == $past(rx_arp_count) ||
                  rx_arp_count == $past(rx_arp_count) + 8'd1));
endmodule

bind arp_resolver_top arp_resolver_chk u_chk (
    .clk(clk), .rst(rst), .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid),
    .tx_tready(tx_tready), .tx_tlast(tx_tlast), .rsv_done(rsv_done),
    .rsv_ok(rsv_ok), .rsv_mac(rsv_mac), .rx_arp_count(rx_arp_count)
);

// File: tb/sim_arp_resolver_top.sv
`timescale 1ns/1ps
module sim_arp_resolver_top;
    localparam int TMO = 2000;
    localparam logic [47:0] MY_MAC = 48'h02_11_22_33_44_55;
    localparam logic [31:0] MY_IP  = 32'hC0A8_0001;
    localparam logic [47:0] BCAST  = 48'hFFFF_FFFF_FFFF;

    logic clk = 0, rst = 1;
    logic [7:0] rx_tdata = 0; logic rx_tvalid = 0, rx_tlast = 0;
    logic [7:0] tx_tdata; logic tx_tvalid, tx_tlast, tx_tready;
    logic rsv_req = 0; logic [31:0] rsv_ip = 0;
    logic rsv_done, rsv_ok; logic [47:0] rsv_mac; logic [7:0] rx_arp_count;

    always #2.5 clk = ~clk;

    arp_resolver_top #(.TIMEOUT_CYCLES(TMO)) u0 (
        .clk, .rst, .our_mac(MY_MAC), .our_ip(MY_IP),
        .rx_tdata, .rx_tvalid, .rx_tlast, .tx_tdata, .tx_tvalid, .tx_tready, .tx_tlast,
        .rsv_req, .rsv_ip, .rsv_done, .rsv_ok, .rsv_mac, .rx_arp_count
    );

    int checks = 0, failures = 0, cyc = 0, pat = 0;
    bit finished = 0;
    logic [8:0]  exp_tx[$];
    logic [48:0] exp_res[$];

    task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int i, input logic [15:0] op, input logic [15:0] etype,
        input logic [47:0] dst, input logic [47:0] sha, input logic [31:0] spa,
        input logic [47:0] tha, input logic [31:0] tpa);
        logic [7:0] h[0:9];
        h = '{8'h00, 8'h01, 8'h08, 8'h00, 8'h06, 8'h04, op[15:8], op[7:0], 8'h0, 8'h0};
        if (i < 6) return dst[47-8*i -: 8];
        if (i < 12) return sha[47-8*(i-6) -: 8];
        if (i < 14) return (i == 12) ? etype[15:8] : etype[7:0];
        if (i < 22) return h[i-14];
        if (i < 28) return sha[47-8*(i-22) -: 8];
        if (i < 32) return spa[31-8*(i-28) -: 8];
        if (i < 38) return tha[47-8*(i-32) -: 8];
        if (i < 42) return tpa[31-8*(i-38) -: 8];
        return 8'h00;
    endfunction

    task automatic push_frame(input logic [15:0] op, input logic [47:0] dst,
                              input logic [47:0] tha, input logic [31:0] tpa);
        for (int i = 0; i < 42; i++)
            exp_tx.push_back({i == 41, fb(i, op, 16'h0806, dst, MY_MAC, MY_IP, tha, tpa)});
    endtask

    task automatic send_rx(input logic [15:0] op, input logic [15:0] etype, input logic [47:0] sha,
                           input logic [31:0] spa, input logic [31:0] tpa, input int len);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rx_tvalid = 1; rx_tdata = fb(i, op, etype, BCAST, sha, spa, 48'h0, tpa);
            rx_tlast = (i == len - 1);
        end
        @(posedge clk); #1; rx_tvalid = 0; rx_tlast = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic request(input logic [31:0] ip);
        @(posedge clk); #1; rsv_req = 1; rsv_ip = ip;
        @(posedge clk); #1; rsv_req = 0;
    endtask

    task automatic drain();
        while (exp_tx.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // ready stutters one cycle in four
    initial begin
        tx_tready = 0;
        forever begin
            @(posedge clk); #1;
            pat++; cyc++;
            tx_tready = (pat % 4 != 1);
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_tvalid && tx_tready) begin
                if (exp_tx.size() == 0) check(0, "R8 unexpected tx byte", {55'h0, tx_tlast, tx_tdata}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_tx.pop_front();
                    check({tx_tlast, tx_tdata} == e, "R2/R7 tx byte", {tx_tlast, tx_tdata}, e);
                end
            end
            if (rsv_done) begin
                if (exp_res.size() == 0) check(0, "R10 unexpected done", {rsv_ok, rsv_mac}, 0);
                else begin
                    logic [48:0] e;
                    e = exp_res.pop_front();
                    check({rsv_ok, rsv_mac} == e, "R4/R6 result", {rsv_ok, rsv_mac}, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int exp_cnt, t0;
        logic [31:0] ip_a, ip_b, ip_x;
        logic [47:0] mac_a, mac_r;
        ip_a = 32'h0A00_0005; ip_b = 32'h0A00_0009; ip_x = 32'h0A00_0077;
        mac_a = 48'hAA_BB_CC_00_11_22; mac_r = 48'h06_05_04_03_02_01;
        exp_cnt = 0;
        repeat (5) @(posedge clk); #1; rst = 0;
        @(negedge clk);
        // R1
        check(tx_tvalid == 0, "R1 tvalid", tx_tvalid, 0);
        check(rsv_done == 0, "R1 done", rsv_done, 0);
        check(rx_arp_count == 0, "R1 count", rx_arp_count, 0);

        // R2 miss sends broadcast request, R10 wrong reply ignored, R4 match
        push_frame(16'h0001, BCAST, 48'h0, ip_a);
        exp_res.push_back({1'b1, mac_a});
        request(ip_a);
        drain();
        check(exp_tx.size() == 0, "R2 request frame sent", exp_tx.size(), 0);
        send_rx(16'h0002, 16'h0806, 48'h11_11_11_11_11_11, ip_x, MY_IP, 42); exp_cnt++;
        repeat (10) @(posedge clk);
        check(exp_res.size() == 1, "R10 no completion on other sender", exp_res.size(), 1);
        send_rx(16'h0002, 16'h0806, mac_a, ip_a, MY_IP, 60); exp_cnt++;
        repeat (5) @(posedge clk);
        check(exp_res.size() == 0, "R4 resolved", exp_res.size(), 0);
        check(rx_arp_count == exp_cnt[7:0], "R9 count after replies", rx_arp_count, exp_cnt);

        // R5 cache hit, result one cycle later, no frame
        exp_res.push_back({1'b1, mac_a});
        request(ip_a);
        @(negedge clk);
        check(rsv_done == 1, "R5 hit done next cycle", rsv_done, 1);
        repeat (60) @(posedge clk);
        check(exp_res.size() == 0, "R5 hit result", exp_res.size(), 0);

        // R7 reply to request for our IP
        push_frame(16'h0002, mac_r, mac_r, ip_x);
        send_rx(16'h0001, 16'h0806, mac_r, ip_x, MY_IP, 42); exp_cnt++;
        drain();
        check(exp_tx.size() == 0, "R7 reply frame sent", exp_tx.size(), 0);

        // R8 request for another IP: counted, no frame
        send_rx(16'h0001, 16'h0806, mac_r, ip_x, ip_b, 42); exp_cnt++;
        repeat (100) @(posedge clk);
        check(rx_arp_count == exp_cnt[7:0], "R8 counted", rx_arp_count, exp_cnt);

        // R9 non-ARP type and short frame not counted
        send_rx(16'h0001, 16'h0800, mac_r, ip_x, MY_IP, 42);
        send_rx(16'h0001, 16'h0806, mac_r, ip_x, MY_IP, 30);
        repeat (100) @(posedge clk);
        check(rx_arp_count == exp_cnt[7:0], "R9 rejects bad frames", rx_arp_count, exp_cnt);

        // R6 timeout on unanswered miss
        push_frame(16'h0001, BCAST, 48'h0, ip_b);
        exp_res.push_back({1'b0, 48'h0});
        t0 = cyc;
        request(ip_b);
        @(negedge clk);
        while (!rsv_done) @(negedge clk);
        check((cyc - t0) >= TMO, "R6 waited full window", cyc - t0, TMO);
        @(negedge clk);
        check(exp_res.size() == 0 && exp_tx.size() == 0, "R6 fail result", exp_res.size(), 0);

        // R9 wrap at 256
        for (int k = 0; k < 256; k++)
            send_rx(16'h0002, 16'h0806, mac_r, ip_x, MY_IP, 42);
        repeat (5) @(posedge clk);
        check(rx_arp_count == exp_cnt[7:0], "R9 wraps modulo 256", rx_arp_count, exp_cnt);
        check(exp_res.size() == 0, "R10 idle replies ignored", exp_res.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule